// File: doc/BRIEF.md
# Fractional SPI Clock Generator

This block derives a serial clock from a fast reference clock by adding a frequency word to an 11-bit phase accumulator on every active reference cycle. The accumulator wraps at 2048. The serial clock follows the top bit of the accumulator, so its average rate is the reference rate times the word divided by 2048. The block also produces two one-cycle strobes that a shift engine uses. One marks the clock edge on which outgoing data changes, and the other marks the edge on which incoming data is captured.

A small bank of profiles holds the per-target settings:
- a 16-bit frequency word;
- a flag that re-zeroes the phase whenever a transfer starts;
- two independent edge selectors, one for the launch strobe and one for the sample strobe.

A global register holds three settings:
- the clock idle level;
- a gate that stops the clock while no target is selected;
- the level the data-out line rests at between transfers.

The transfer engine picks a profile and holds the run input high for the length of a transfer.

Top module: `hsck_clkgen`

## Requirements
- R1: After a synchronous reset, sck_o, launch_o, sample_o and mosi_idle_o are 0, all profiles hold zero, and the global settings are zero.
- R2: On each active cycle the 11-bit phase advances by the selected word modulo 2048. sck_o is registered and equals the idle level XOR the phase top bit. Starting from phase 0, 2048 active cycles give exactly word rising SCK edges (for idle level 0).
- R3: A word larger than 1024 acts as 1024, and SCK then toggles on every reference cycle.
- R4: With a selected word of 0, SCK stays at its idle level and neither strobe fires.
- R5: On the first cycle of run (a 0-to-1 change), a profile whose restart flag is 1 clears the phase to 0. With the flag at 0, the phase resumes from the value it held.
- R6: While run is 0, the phase holds, SCK is at its idle level one cycle later, and no strobe fires.
- R7: launch_o is high for one cycle, in the cycle where sck_o rises when the profile's launch selector is 1, or where it falls when the selector is 0. It fires only while the clock is active.
- R8: sample_o follows the same rule as launch_o but uses the profile's own sample selector, independently of the launch selector.
- R9: The global idle-level bit sets SCK while stopped. An active SCK is the idle level XOR the phase top bit.
- R10: With the gate bit at 1 and cs_active_i at 0, SCK is held idle, the phase freezes and no strobe fires. With the gate bit at 0, cs_active_i has no effect.
- R11: mosi_idle_o is the global data-out idle bit, delayed by one register.
- R12: The selected profile's settings apply in the cycle it is selected. A write to one profile leaves the clock produced from another profile unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock |
| rst_i | input | 1 | Synchronous active-high reset |
| prof_sel_i | input | IDX_W | Profile used by the current transfer |
| run_i | input | 1 | Clock enable from the transfer engine |
| cs_active_i | input | 1 | High while any target is selected |
| prof_we_i | input | 1 | Profile write strobe |
| prof_waddr_i | input | IDX_W | Profile written |
| prof_freq_i | input | FREQ_W | Frequency word to write |
| prof_restart_i | input | 1 | Re-zero phase at transfer start |
| prof_launch_rise_i | input | 1 | 1: launch on rising SCK, 0: falling |
| prof_sample_rise_i | input | 1 | 1: capture on rising SCK, 0: falling |
| glob_we_i | input | 1 | Global settings write strobe |
| glob_cpol_i | input | 1 | SCK idle level |
| glob_gate_i | input | 1 | Stop SCK while no target is selected |
| glob_mosi_idle_i | input | 1 | Data-out idle level |
| sck_o | output | 1 | Serial clock |
| launch_o | output | 1 | Data launch strobe |
| sample_o | output | 1 | Data capture strobe |
| mosi_idle_o | output | 1 | Data-out idle level |

## Verification
The bench drives a 2048-cycle window from phase 0 with word 683. It counts edges and expects exactly 683 rising and 683 falling edges. An accumulator that toggled on every wrap, or that dropped the carry, would give half or a drifting count. It stops a transfer mid-phase and restarts under a profile without the restart flag, expecting SCK to rise on the first cycle. A design that always cleared the phase would stay low there. It also checks words of 0 and above 1024, gating with and without a selected target, and an inverted idle level. A design that clamped wrongly, ignored the gate, or leaked strobes while stopped is caught by the per-cycle comparison with the reference model.

// File: rtl/hsck_pkg.sv
package hsck_pkg;

  // per-profile edge and phase controls
  typedef struct packed {
    logic restart;
    logic launch_rise;
    logic sample_rise;
  } prof_edge_t;

  // global controls shared by all profiles
  typedef struct packed {
    logic cpol;
    logic gate_idle;
    logic mosi_idle;
  } glob_cfg_t;

endpackage

// File: rtl/hsck_prof_bank.sv
module hsck_prof_bank
  import hsck_pkg::*;
#(
  parameter int NUM_PROF = 4,
  parameter int IDX_W    = 2,
  parameter int FREQ_W   = 16
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic              we_i,
  input  logic [IDX_W-1:0]  waddr_i,
  input  logic [FREQ_W-1:0] wfreq_i,
  input  prof_edge_t        wedge_i,
  input  logic [IDX_W-1:0]  raddr_i,
  output logic [FREQ_W-1:0] rfreq_o,
  output prof_edge_t        redge_o
);

  logic [FREQ_W-1:0] freq_q [NUM_PROF];
  prof_edge_t        edge_q [NUM_PROF];

  for (genvar p = 0; p < NUM_PROF; p++) begin : g_prof
    always_ff @(posedge clk_i) begin
      if (rst_i) begin
        freq_q[p] <= '0;
        edge_q[p] <= '0;
      end else if (we_i && (waddr_i == IDX_W'(p))) begin
        freq_q[p] <= wfreq_i;
        edge_q[p] <= wedge_i;
      end
    end
  end

  assign rfreq_o = freq_q[raddr_i];
  assign redge_o = edge_q[raddr_i];

endmodule

// File: rtl/hsck_phase_acc.sv
module hsck_phase_acc #(
  parameter int FREQ_W  = 16,
  parameter int PHASE_W = 11
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic              run_i,
  input  logic              adv_i,
  input  logic              restart_i,
  input  logic [FREQ_W-1:0] word_i,
  output logic              phase_nxt_o
);

  localparam int HALF = 1 << (PHASE_W - 1);

  logic [PHASE_W-1:0] acc_q, acc_n, step;
  logic               run_q, start;

  // words beyond half the modulus would alias; cap at one toggle per cycle
  always_comb begin
    if (word_i > FREQ_W'(HALF)) step = PHASE_W'(HALF);
    else                        step = word_i[PHASE_W-1:0];
  end

  assign start = run_i & ~run_q;

  always_comb begin
    acc_n = acc_q;
    if (start && restart_i) acc_n = '0;
    else if (adv_i)         acc_n = acc_q + step;
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      acc_q <= '0;
      run_q <= 1'b0;
    end else begin
      acc_q <= acc_n;
      run_q <= run_i;
    end
  end

  assign phase_nxt_o = acc_n[PHASE_W-1];

endmodule

// File: rtl/hsck_edge_gen.sv
module hsck_edge_gen (
  input  logic clk_i,
  input  logic rst_i,
  input  logic active_i,
  input  logic phase_nxt_i,
  input  logic cpol_i,
  input  logic launch_rise_i,
  input  logic sample_rise_i,
  input  logic mosi_lvl_i,
  output logic sck_o,
  output logic launch_o,
  output logic sample_o,
  output logic mosi_o
);

  logic sck_nxt, rise, fall;

  assign sck_nxt = active_i ? (cpol_i ^ phase_nxt_i) : cpol_i;
  assign rise    = ~sck_o & sck_nxt;
  assign fall    = sck_o & ~sck_nxt;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      sck_o    <= 1'b0;
      launch_o <= 1'b0;
      sample_o <= 1'b0;
      mosi_o   <= 1'b0;
    end else begin
      sck_o    <= sck_nxt;
      launch_o <= active_i & (launch_rise_i ? rise : fall);
      sample_o <= active_i & (sample_rise_i ? rise : fall);
      mosi_o   <= mosi_lvl_i;
    end
  end

endmodule

// File: rtl/hsck_clkgen.sv
module hsck_clkgen
  import hsck_pkg::*;
#(
  parameter int NUM_PROF = 4,
  parameter int FREQ_W   = 16,
  parameter int PHASE_W  = 11,
  localparam int IDX_W   = $clog2(NUM_PROF)
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic [IDX_W-1:0]  prof_sel_i,
  input  logic              run_i,
  input  logic              cs_active_i,
  input  logic              prof_we_i,
  input  logic [IDX_W-1:0]  prof_waddr_i,
  input  logic [FREQ_W-1:0] prof_freq_i,
  input  logic              prof_restart_i,
  input  logic              prof_launch_rise_i,
  input  logic              prof_sample_rise_i,
  input  logic              glob_we_i,
  input  logic              glob_cpol_i,
  input  logic              glob_gate_i,
  input  logic              glob_mosi_idle_i,
  output logic              sck_o,
  output logic              launch_o,
  output logic              sample_o,
  output logic              mosi_idle_o
);

  glob_cfg_t         glob_q;
  prof_edge_t        wedge, sel_edge;
  logic [FREQ_W-1:0] sel_freq;
  logic              active, phase_nxt;
  logic              cur_cpol, cur_gate, cur_mosi;

  always_ff @(posedge clk_i) begin
    if (rst_i) glob_q <= '0;
    else if (glob_we_i) begin
      glob_q.cpol      <= glob_cpol_i;
      glob_q.gate_idle <= glob_gate_i;
      glob_q.mosi_idle <= glob_mosi_idle_i;
    end
  end

  assign cur_cpol = glob_q.cpol;
  assign cur_gate = glob_q.gate_idle;
  assign cur_mosi = glob_q.mosi_idle;

  assign wedge.restart     = prof_restart_i;
  assign wedge.launch_rise = prof_launch_rise_i;
  assign wedge.sample_rise = prof_sample_rise_i;

  hsck_prof_bank #(
    .NUM_PROF (NUM_PROF),
    .IDX_W    (IDX_W),
    .FREQ_W   (FREQ_W)
  ) u_bank (
    .clk_i   (clk_i),
    .rst_i   (rst_i),
    .we_i    (prof_we_i),
    .waddr_i (prof_waddr_i),
    .wfreq_i (prof_freq_i),
    .wedge_i (wedge),
    .raddr_i (prof_sel_i),
    .rfreq_o (sel_freq),
    .redge_o (sel_edge)
  );

  assign active = run_i && (sel_freq != '0) && !(cur_gate && !cs_active_i);

  hsck_phase_acc #(
    .FREQ_W  (FREQ_W),
    .PHASE_W (PHASE_W)
  ) u_acc (
    .clk_i       (clk_i),
    .rst_i       (rst_i),
    .run_i       (run_i),
    .adv_i       (active),
    .restart_i   (sel_edge.restart),
    .word_i      (sel_freq),
    .phase_nxt_o (phase_nxt)
  );

  hsck_edge_gen u_edge (
    .clk_i         (clk_i),
    .rst_i         (rst_i),
    .active_i      (active),
    .phase_nxt_i   (phase_nxt),
    .cpol_i        (cur_cpol),
    .launch_rise_i (sel_edge.launch_rise),
    .sample_rise_i (sel_edge.sample_rise),
    .mosi_lvl_i    (cur_mosi),
    .sck_o         (sck_o),
    .launch_o      (launch_o),
    .sample_o      (sample_o),
    .mosi_o        (mosi_idle_o)
  );

endmodule

// File: rtl/hsck_clkgen_chk.sv
module hsck_clkgen_chk #(
  parameter int FREQ_W = 16
) (
  input logic              clk_i,
  input logic              rst_i,
  input logic              run_i,
  input logic              cs_active_i,
  input logic              sck_o,
  input logic              launch_o,
  input logic              sample_o,
  input logic              mosi_idle_o,
  input logic              cpol_i,
  input logic              gate_i,
  input logic              mosi_i,
  input logic [FREQ_W-1:0] freq_i
);

  a_r7_launch_on_edge: assert property (@(posedge clk_i) disable iff (rst_i)
    launch_o |-> (sck_o != $past(sck_o)));

  a_r7_launch_single: assert property (@(posedge clk_i) disable iff (rst_i)
    launch_o |=> !launch_o);

  a_r8_sample_on_edge: assert property (@(posedge clk_i) disable iff (rst_i)
    sample_o |-> (sck_o != $past(sck_o)));

  a_r8_sample_single: assert property (@(posedge clk_i) disable iff (rst_i)
    sample_o |=> !sample_o);

  a_r6_idle_stopped: assert property (@(posedge clk_i) disable iff (rst_i)
    (!$past(rst_i) && !$past(run_i)) |->
      (sck_o == $past(cpol_i) && !launch_o && !sample_o));

  a_r4_zero_word: assert property (@(posedge clk_i) disable iff (rst_i)
    (!$past(rst_i) && $past(freq_i) == '0) |->
      (sck_o == $past(cpol_i) && !launch_o && !sample_o));

  a_r10_gated: assert property (@(posedge clk_i) disable iff (rst_i)
    (!$past(rst_i) && $past(gate_i) && !$past(cs_active_i)) |->
      (sck_o == $past(cpol_i) && !launch_o && !sample_o));

  a_r11_mosi_level: assert property (@(posedge clk_i) disable iff (rst_i)
    !$past(rst_i) |-> (mosi_idle_o == $past(mosi_i)));

endmodule

bind hsck_clkgen hsck_clkgen_chk #(.FREQ_W(FREQ_W)) u_chk (
  .clk_i       (clk_i),
  .rst_i       (rst_i),
  .run_i       (run_i),
  .cs_active_i (cs_active_i),
  .sck_o       (sck_o),
  .launch_o    (launch_o),
  .sample_o    (sample_o),
  .mosi_idle_o (mosi_idle_o),
  .cpol_i      (cur_cpol),
  .gate_i      (cur_gate),
  .mosi_i      (cur_mosi),
  .freq_i      (sel_freq)
);

// File: tb/hsck_clkgen_tb.sv
`timescale 1ns/1ps
module hsck_clkgen_tb;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [1:0] sel = '0;
  logic run = 1'b0, cs = 1'b0;
  logic pwe = 1'b0;
  logic [1:0] pwa = '0;
  logic [15:0] pfreq = '0;
  logic prst = 1'b0, plr = 1'b0, psr = 1'b0;
  logic gwe = 1'b0, gcpol = 1'b0, ggate = 1'b0, gmosi = 1'b0;
  logic sck, launch, sample, mosi;

  always #2 clk = ~clk;

  hsck_clkgen u_dut (
    .clk_i (clk), .rst_i (rst), .prof_sel_i (sel), .run_i (run),
    .cs_active_i (cs), .prof_we_i (pwe), .prof_waddr_i (pwa),
    .prof_freq_i (pfreq), .prof_restart_i (prst),
    .prof_launch_rise_i (plr), .prof_sample_rise_i (psr),
    .glob_we_i (gwe), .glob_cpol_i (gcpol), .glob_gate_i (ggate),
    .glob_mosi_idle_i (gmosi), .sck_o (sck), .launch_o (launch),
    .sample_o (sample), .mosi_idle_o (mosi)
  );

  // behavioural reference model
  int m_freq [4];
  bit m_rs [4], m_lr [4], m_sr [4];
  bit m_cpol, m_gate, m_mg, m_runq, m_sck, m_l, m_s, m_mo;
  int m_acc;

  always @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < 4; i++) begin
        m_freq[i] = 0; m_rs[i] = 0; m_lr[i] = 0; m_sr[i] = 0;
      end
      m_cpol = 0; m_gate = 0; m_mg = 0; m_runq = 0;
      m_sck = 0; m_l = 0; m_s = 0; m_mo = 0; m_acc = 0;
    end else begin
      int f, w;
      bit act, st, nx, rise, fall;
      f = m_freq[sel];
      w = (f > 1024) ? 1024 : f;
      act = run && (f != 0) && !(m_gate && !cs);
      st = run && !m_runq;
      if (st && m_rs[sel]) m_acc = 0;
      else if (act) m_acc = (m_acc + w) % 2048;
      m_runq = run;
      nx = act ? (m_cpol ^ (m_acc >= 1024)) : m_cpol;
      rise = !m_sck && nx;
      fall = m_sck && !nx;
      m_l = act && (m_lr[sel] ? rise : fall);
      m_s = act && (m_sr[sel] ? rise : fall);
      m_sck = nx;
      m_mo = m_mg;
      if (pwe) begin
        m_freq[pwa] = pfreq; m_rs[pwa] = prst; m_lr[pwa] = plr; m_sr[pwa] = psr;
      end
      if (gwe) begin
        m_cpol = gcpol; m_gate = ggate; m_mg = gmosi;
      end
    end
  end

  int checks = 0, fails = 0;
  int rise_cnt = 0, fall_cnt = 0, l_cnt = 0, s_cnt = 0;
  bit prev_sck = 0;
  bit done = 0;

  task automatic chk(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic clr();
    rise_cnt = 0; fall_cnt = 0; l_cnt = 0; s_cnt = 0;
  endtask

  task automatic tick();
    @(negedge clk);
    if (!rst) begin
      chk(sck == m_sck, "R2 sck vs model", sck, m_sck);
      chk(launch == m_l, "R7 launch vs model", launch, m_l);
      chk(sample == m_s, "R8 sample vs model", sample, m_s);
      chk(mosi == m_mo, "R11 mosi vs model", mosi, m_mo);
    end
    if (sck && !prev_sck) rise_cnt++;
    if (!sck && prev_sck) fall_cnt++;
    if (launch) l_cnt++;
    if (sample) s_cnt++;
    prev_sck = sck;
  endtask

  task automatic wprof(int a, int f, bit r, bit l, bit s);
    pwe = 1; pwa = 2'(a); pfreq = 16'(f); prst = r; plr = l; psr = s;
    tick();
    pwe = 0;
  endtask

  task automatic wglob(bit c, bit g, bit m);
    gwe = 1; gcpol = c; ggate = g; gmosi = m;
    tick();
    gwe = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) tick();
    rst = 0;
    tick();
    // R1 reset state
    chk(sck == 0, "R1 sck", sck, 0);
    chk(launch == 0 && sample == 0, "R1 strobes", launch | sample, 0);
    chk(mosi == 0, "R1 mosi", mosi, 0);

    wprof(0, 683, 1, 0, 1);
    wprof(1, 5000, 1, 1, 0);
    wprof(2, 0, 1, 1, 1);
    wprof(3, 683, 0, 1, 1);
    wglob(0, 0, 1);
    tick();
    chk(mosi == 1, "R11 mosi follows global", mosi, 1);

    // R2 exact edge count over a full modulus window
    sel = 0; run = 1; tick(); clr();
    repeat (2048) tick();
    chk(rise_cnt == 683, "R2 rising edges", rise_cnt, 683);
    chk(fall_cnt == 683, "R2 falling edges", fall_cnt, 683);
    chk(l_cnt == 683, "R7 launch on falling", l_cnt, 683);
    chk(s_cnt == 683, "R8 sample on rising", s_cnt, 683);
    run = 0; tick();
    chk(sck == 0, "R6 idle after stop", sck, 0);

    // R3 clamp
    sel = 1; run = 1; tick(); clr();
    repeat (64) tick();
    chk(rise_cnt == 32, "R3 toggle every cycle", rise_cnt, 32);
    chk(l_cnt == 32 && s_cnt == 32, "R8 independent strobes", l_cnt + s_cnt, 64);
    run = 0; tick();

    // R4 zero word
    sel = 2; run = 1; clr();
    repeat (50) tick();
    chk(rise_cnt == 0 && l_cnt == 0 && s_cnt == 0, "R4 no activity", rise_cnt + l_cnt + s_cnt, 0);
    chk(sck == 0, "R4 idle level", sck, 0);
    run = 0; tick();

    // R5 restart versus resume
    sel = 0; run = 1; tick(); tick();
    run = 0; repeat (3) tick();
    chk(sck == 0, "R6 held idle", sck, 0);
    sel = 3; run = 1; tick();
    chk(sck == 1, "R5 resume from held phase", sck, 1);
    run = 0; tick();
    sel = 0; run = 1; tick();
    chk(sck == 0, "R5 restart cycle", sck, 0);
    tick();
    chk(sck == 0, "R5 restart step1", sck, 0);
    tick();
    chk(sck == 1, "R5 restart step2", sck, 1);
    run = 0; tick();

    // R9 inverted idle level
    wglob(1, 0, 0);
    tick();
    chk(sck == 1, "R9 idle high", sck, 1);
    chk(mosi == 0, "R11 mosi cleared", mosi, 0);
    sel = 0; run = 1; tick(); clr();
    repeat (2048) tick();
    chk(rise_cnt == 683, "R9 edges with idle high", rise_cnt, 683);
    run = 0; tick();
    chk(sck == 1, "R9 idle after stop", sck, 1);

    // R10 gating
    wglob(0, 1, 0);
    cs = 0; sel = 1; run = 1; tick(); clr();
    repeat (20) tick();
    chk(rise_cnt == 0 && l_cnt == 0, "R10 gated", rise_cnt + l_cnt, 0);
    chk(sck == 0, "R10 gated idle", sck, 0);
    cs = 1; clr();
    repeat (20) tick();
    chk(rise_cnt == 10, "R10 selected runs", rise_cnt, 10);
    cs = 0;
    wglob(0, 0, 0);
    clr();
    repeat (20) tick();
    chk(rise_cnt == 10, "R10 gate off ignores select", rise_cnt, 10);
    run = 0; tick();

    // R12 writes to another profile during a transfer
    sel = 0; run = 1; tick(); clr();
    for (int i = 0; i < 2048; i++) begin
      pwe = 1; pwa = 2'd1; pfreq = 16'(i % 7); prst = i[0]; plr = i[1]; psr = i[2];
      tick();
    end
    pwe = 0;
    chk(rise_cnt == 683, "R12 other profile writes", rise_cnt, 683);
    run = 0; tick();
    sel = 1; run = 1;
    repeat (40) tick();
    run = 0; repeat (2) tick();

    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule